// File: doc/BRIEF.md
# Synchronous Slave Serial Transmitter

This block sends parallel words out over a half-duplex synchronous serial link on which another device is the master and drives the shift clock. Software places a word in a one-entry holding register. If nothing is being shifted, the word moves straight into the shift register. Otherwise it waits in the holding register until the current word has been fully sent. Each falling edge of the external shift clock puts the next bit on the data pin, least significant bit first, so the master can sample it on the rising edge. A ninth data bit can be appended to each word.

The external clock is brought into the system clock domain through a two-flop synchronizer and an edge detector. The system clock must therefore run at least four times faster than the shift clock. Two flags are provided: a holding-register-empty flag, which is gated with an interrupt enable to form an interrupt request, and a shift-register-empty status. The transmitter runs only in slave operation with the transmitter switched on.

Top module: `sync_slave_tx`

## Requirements
- R1: After reset, `hold_empty` is 1, `shift_empty` is 1, `sdo` is 1 and both registers hold zero.
- R2: The transmitter is active only when `port_en`, `sync_mode` and `tx_en` are 1 and `clk_src_master`, `rx_single_en` and `rx_cont_en` are 0. `sdo_oe` equals this condition. While the transmitter is inactive, writes are ignored and both registers are cleared on the next clock edge, leaving `hold_empty` = 1 and `shift_empty` = 1.
- R3: A write made while `shift_empty` is 1 loads the word into the shift register on that clock edge. After that edge `shift_empty` is 0, `sdo` shows bit 0 of the word, and `hold_empty` stays 1.
- R4: A write made while a word is being shifted and `hold_empty` is 1 goes into the holding register, and `hold_empty` becomes 0.
- R5: When the last bit of the current word is finished, a held word moves into the shift register on the same edge, and only then does `hold_empty` return to 1.
- R6: Bits leave least significant bit first. The next bit appears on `sdo` at the second system clock edge after the first edge that samples `sck_in` low following a high sample.
- R7: With `nine_bit` = 1 at the time of the write, the value of `bit9_val` at that time is sent as a ninth bit after the eight data bits. With `nine_bit` = 0, exactly eight bits are sent.
- R8: `tx_irq` is 1 exactly when `hold_empty` and `tx_irq_en` are both 1.
- R9: A write made while the holding register is already full is dropped, and the held word is unchanged.
- R10: When the last bit finishes and no word is held, `shift_empty` returns to 1 on that edge, and `sdo` rests at 1 while nothing is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_src_master | input | 1 | 1 = internal clock source (master role); must be 0 |
| tx_en | input | 1 | Transmitter enable |
| rx_single_en | input | 1 | Single receive enable; must be 0 |
| rx_cont_en | input | 1 | Continuous receive enable; must be 0 |
| nine_bit | input | 1 | Append a ninth bit to words written now |
| bit9_val | input | 1 | Value of the ninth bit for words written now |
| tx_irq_en | input | 1 | Interrupt enable for the holding-register-empty flag |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Word to send |
| sck_in | input | 1 | External shift clock from the master |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data pin |
| hold_empty | output | 1 | Holding register is empty |
| shift_empty | output | 1 | Shift register is idle |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
A wrong bit counter shows up on `sdo` within one shift clock period: a bit is sent twice, or the next word starts early. A lost or premature hand-off from the holding register shows up at once, because `hold_empty` and `shift_empty` then disagree with the number of words written and bits clocked. Synchronizer latency errors move the `sdo` transition by one or more system cycles. The bench compares all outputs against its reference model on every cycle, so any of these faults is reported on the first cycle in which it appears.

// File: rtl/sst_pkg.sv
package sst_pkg;
    localparam int unsigned SST_DATA_W = 8;
    localparam int unsigned SST_SYNC_STAGES = 2;

    function automatic logic tx_path_active(
        input logic en, input logic syn, input logic master,
        input logic txe, input logic rxs, input logic rxc);
        return en & syn & ~master & txe & ~rxs & ~rxc;
    endfunction
endpackage

// File: rtl/sst_edge_sync.sv
module sst_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall
);
    logic [STAGES:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign fall = pipe_q[STAGES] & ~pipe_q[STAGES-1];

    // A falling edge lasts exactly one system cycle
    assert_single_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
    parameter int unsigned WORD_W = 9,
    parameter int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic [CNT_W-1:0]  load_len,
    input  logic              advance,
    input  logic              stop,
    output logic              cur_bit,
    output logic              on_last,
    output logic              busy
);
    typedef struct packed {
        logic              busy;
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  left;
    } sh_t;

    sh_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (load) begin
            st_d.busy = 1'b1;
            st_d.sh   = load_word;
            st_d.left = load_len;
        end else if (advance && st_q.busy) begin
            st_d.sh   = st_q.sh >> 1;
            st_d.left = st_q.left - 1'b1;
        end else if (stop) begin
            st_d.busy = 1'b0;
            st_d.left = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_bit = st_q.busy ? st_q.sh[0] : 1'b1;
    assign on_last = (st_q.left == CNT_W'(1));
    assign busy    = st_q.busy;

    // A busy shifter always has bits left to send
    assert_busy_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.left != '0));
    // The controller never shifts past the last bit
    assert_no_overshift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && st_q.busy) |-> !on_last);
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
    import sst_pkg::*;
#(
    parameter int unsigned DATA_W      = SST_DATA_W,
    parameter int unsigned SYNC_STAGES = SST_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              sync_mode,
    input  logic              clk_src_master,
    input  logic              tx_en,
    input  logic              rx_single_en,
    input  logic              rx_cont_en,
    input  logic              nine_bit,
    input  logic              bit9_val,
    input  logic              tx_irq_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sck_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              hold_empty,
    output logic              shift_empty,
    output logic              tx_irq
);
    localparam int unsigned WORD_W = DATA_W + 1;
    localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

    typedef struct packed {
        logic              hold_full;
        logic              hold_nine;
        logic [WORD_W-1:0] hold_word;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              active, sck_fall, sh_busy, sh_last, sh_bit;
    logic              done, adv, free;
    logic              ld, stop;
    logic [WORD_W-1:0] ld_word;
    logic [CNT_W-1:0]  ld_len;

    sst_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sck_in), .fall(sck_fall)
    );

    sst_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clear(~active),
        .load(ld), .load_word(ld_word), .load_len(ld_len),
        .advance(adv), .stop(stop),
        .cur_bit(sh_bit), .on_last(sh_last), .busy(sh_busy)
    );

    always_comb begin
        active  = tx_path_active(port_en, sync_mode, clk_src_master,
                                 tx_en, rx_single_en, rx_cont_en);
        done    = sck_fall & sh_busy & sh_last;
        adv     = sck_fall & sh_busy & ~sh_last;
        ctl_d   = ctl_q;
        ld      = 1'b0;
        stop    = 1'b0;
        ld_word = '0;
        ld_len  = '0;
        free    = ~sh_busy;
        if (!active) begin
            ctl_d = '0;
        end else begin
            if (done) begin
                if (ctl_q.hold_full) begin
                    ld              = 1'b1;
                    ld_word         = ctl_q.hold_word;
                    ld_len          = ctl_q.hold_nine ? CNT_W'(WORD_W) : CNT_W'(DATA_W);
                    ctl_d.hold_full = 1'b0;
                end else begin
                    stop = 1'b1;
                    free = 1'b1;
                end
            end
            if (wr_valid) begin
                if (free) begin
                    ld      = 1'b1;
                    ld_word = {bit9_val, wr_data};
                    ld_len  = nine_bit ? CNT_W'(WORD_W) : CNT_W'(DATA_W);
                end else if (!ctl_d.hold_full) begin
                    ctl_d.hold_full = 1'b1;
                    ctl_d.hold_nine = nine_bit;
                    ctl_d.hold_word = {bit9_val, wr_data};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sdo         = sh_bit;
    assign sdo_oe      = active;
    assign hold_empty  = ~ctl_q.hold_full;
    assign shift_empty = ~sh_busy;
    assign tx_irq      = ~ctl_q.hold_full & tx_irq_en;

    // A held word always waits behind a word being shifted
    assert_hold_needs_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.hold_full |-> sh_busy);
    // An idle write starts shifting at once
    assert_idle_write_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wr_valid && !sh_busy) |=> !shift_empty);
    // End of word with a held word: hand-off keeps shifting and empties the holding register
    assert_handoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && done && ctl_q.hold_full && !wr_valid) |=> (!shift_empty && hold_empty));
    // Leaving the active condition clears both registers
    assert_disable_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (hold_empty && shift_empty));
    // A write into a full holding register leaves it untouched
    assert_full_write_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ctl_q.hold_full && !done && wr_valid) |=> $stable(ctl_q.hold_word));
endmodule

// File: tb/sync_slave_tx_bench.sv
module sync_slave_tx_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_en = 0, sync_mode = 0, clk_src_master = 0, tx_en = 0;
    logic rx_single_en = 0, rx_cont_en = 0, nine_bit = 0, bit9_val = 0;
    logic tx_irq_en = 0, wr_valid = 0, sck_in = 0;
    logic [7:0] wr_data = 8'h00;
    logic sdo, sdo_oe, hold_empty, shift_empty, tx_irq;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    sync_slave_tx u_sync_slave_tx (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
        .clk_src_master(clk_src_master), .tx_en(tx_en),
        .rx_single_en(rx_single_en), .rx_cont_en(rx_cont_en),
        .nine_bit(nine_bit), .bit9_val(bit9_val), .tx_irq_en(tx_irq_en),
        .wr_valid(wr_valid), .wr_data(wr_data), .sck_in(sck_in),
        .sdo(sdo), .sdo_oe(sdo_oe), .hold_empty(hold_empty),
        .shift_empty(shift_empty), .tx_irq(tx_irq)
    );

    // Behavioural reference model
    bit         m_busy, m_hfull, m_hnine;
    int         m_left;
    logic [8:0] m_word, m_hword;
    bit         sck_hist[$];

    function automatic bit m_active();
        return port_en && sync_mode && !clk_src_master && tx_en && !rx_single_en && !rx_cont_en;
    endfunction

    always @(posedge clk) begin
        bit fall, free;
        if (!rst_n) begin
            m_busy = 0; m_hfull = 0; m_hnine = 0; m_left = 0;
            m_word = '0; m_hword = '0;
            sck_hist = '{0, 0, 0};
        end else begin
            fall = sck_hist[sck_hist.size()-3] && !sck_hist[sck_hist.size()-2];
            sck_hist.push_back(sck_in);
            if (sck_hist.size() > 6) void'(sck_hist.pop_front());
            if (!m_active()) begin
                m_busy = 0; m_hfull = 0; m_hnine = 0; m_left = 0;
                m_word = '0; m_hword = '0;
            end else begin
                free = !m_busy;
                if (fall && m_busy) begin
                    if (m_left > 1) begin
                        m_word = m_word >> 1;
                        m_left--;
                    end else if (m_hfull) begin
                        m_word = m_hword;
                        m_left = m_hnine ? 9 : 8;
                        m_hfull = 0;
                    end else begin
                        m_busy = 0;
                        free = 1;
                    end
                end
                if (wr_valid) begin
                    if (free) begin
                        m_busy = 1;
                        m_word = {bit9_val, wr_data};
                        m_left = nine_bit ? 9 : 8;
                    end else if (!m_hfull) begin
                        m_hfull = 1;
                        m_hword = {bit9_val, wr_data};
                        m_hnine = nine_bit;
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", tag, cyc, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R6 sdo", sdo, m_busy ? m_word[0] : 1'b1);
        chk("R2 sdo_oe", sdo_oe, m_active());
        chk("R5 hold_empty", hold_empty, !m_hfull);
        chk("R3 shift_empty", shift_empty, !m_busy);
        chk("R8 tx_irq", tx_irq, !m_hfull && tx_irq_en);
    endtask

    task automatic tick();
        @(negedge clk);
        if (rst_n) compare_all();
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            sck_in = 1'b1; step(3);
            sck_in = 1'b0; step(3);
        end
    endtask

    task automatic write(input logic [7:0] d);
        wr_data = d; wr_valid = 1'b1;
        tick();
        wr_valid = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done_flag) begin
            done_flag = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
            $finish;
        end
    end

    initial begin
        step(3);
        // R1: reset state
        chk("R1 hold_empty", hold_empty, 1'b1);
        chk("R1 shift_empty", shift_empty, 1'b1);
        chk("R1 sdo", sdo, 1'b1);
        rst_n = 1'b1;
        step(4);

        // R2: writes ignored while transmitter off
        port_en = 1; sync_mode = 1;
        write(8'h5A); step(1);
        chk("R2 ignored while tx off", shift_empty, 1'b1);
        chk("R2 oe low while tx off", sdo_oe, 1'b0);
        tx_en = 1; rx_single_en = 1;
        write(8'h5A); step(1);
        chk("R2 ignored with receive on", shift_empty, 1'b1);
        rx_single_en = 0; clk_src_master = 1;
        write(8'h5A); step(1);
        chk("R2 ignored in master role", shift_empty, 1'b1);
        clk_src_master = 0; step(2);
        chk("R2 oe high when active", sdo_oe, 1'b1);

        // R3, R6: single word, LSB first
        write(8'hA5);
        chk("R3 loaded at once", shift_empty, 1'b0);
        chk("R3 hold stays empty", hold_empty, 1'b1);
        chk("R3 bit0 on sdo", sdo, 1'b1);
        pulse(1);
        chk("R6 bit1 after one clock", sdo, 1'b0);
        pulse(7);
        chk("R10 idle after last bit", shift_empty, 1'b1);
        chk("R10 sdo rests high", sdo, 1'b1);

        // R4, R9, R5: back-to-back words and dropped third write
        tx_irq_en = 1;
        write(8'h3C);
        write(8'hC3);
        chk("R4 second word held", hold_empty, 1'b0);
        chk("R8 irq low while held", tx_irq, 1'b0);
        write(8'hFF);
        chk("R9 full write dropped", hold_empty, 1'b0);
        pulse(8);
        chk("R5 hand-off empties hold", hold_empty, 1'b1);
        chk("R5 still shifting", shift_empty, 1'b0);
        chk("R9 held word not overwritten", sdo, 1'b1);
        pulse(1);
        chk("R9 held word bit1", sdo, 1'b1);
        pulse(7);
        chk("R10 idle after second word", shift_empty, 1'b1);
        tx_irq_en = 0; step(1);
        chk("R8 irq masked", tx_irq, 1'b0);

        // R7: ninth bit
        nine_bit = 1; bit9_val = 1;
        write(8'h00);
        nine_bit = 0; bit9_val = 0;
        pulse(7);
        chk("R7 eighth bit", sdo, 1'b0);
        pulse(1);
        chk("R7 ninth bit sent", sdo, 1'b1);
        chk("R7 still busy on ninth", shift_empty, 1'b0);
        pulse(1);
        chk("R7 done after nine", shift_empty, 1'b1);

        // R2: disable mid-word clears both registers
        write(8'h81); write(8'h7E);
        pulse(2);
        tx_en = 0; step(2);
        chk("R2 clear shift", shift_empty, 1'b1);
        chk("R2 clear hold", hold_empty, 1'b1);
        chk("R2 oe low", sdo_oe, 1'b0);
        tx_en = 1; step(2);

        // Write coinciding with clock activity
        write(8'h96);
        sck_in = 1; step(2);
        write(8'h69);
        sck_in = 0; step(3);
        pulse(20);
        chk("R10 idle at end", shift_empty, 1'b1);

        done_flag = 1;
        report();
        $finish;
    end
endmodule